// File: doc/BRIEF.md
# Two-Bank Row State Tracker

This block sits in an SDRAM controller next to the command bus. On every rising clock edge it decodes the chip-select, row strobe, column strobe and write-enable lines, together with the bank address and row address. From these it keeps, for each of two banks, a record of whether a row is open, which row that is, and whether the bank has a burst in progress. It also enforces a programmable activate-to-column delay separately in each bank.

Column commands may arrive on every clock. They may stay on one bank or alternate between the two open banks. A legal column command gives a one-cycle read or write pulse that names its bank. An illegal access gives a one-cycle error pulse and changes no state. An illegal access is a column command to a closed bank, a column command issued too early, or an activate to a bank that already holds a row. A different row in an open bank can only be reached by precharging that bank and activating it again.

Each bank runs its own state machine with four states. CLOSED holds no row. RCD_WAIT means activated, with the delay still running. ACTIVE means a row is open and ready. BURST means a row is open and a column access is running. The transitions are as follows:
- CLOSED to RCD_WAIT on an activate.
- RCD_WAIT to ACTIVE when the delay counter is zero.
- RCD_WAIT, ACTIVE or BURST to BURST on a legal column command.
- BURST to ACTIVE on a burst stop.
- RCD_WAIT, ACTIVE or BURST to CLOSED on a precharge.

Top module: `bank_row_tracker`

## Requirements
- R1: Commands are decoded only while cs_n is low, with strobes given as (ras_n, cas_n, we_n). Activate is (0,1,1). Precharge is (0,1,0). Read is (1,0,1). Write is (1,0,0). Burst stop is (1,1,0). No-operation is (1,1,1). All other codes, such as (0,0,1), have no effect on any output.
- R2: An activate to a CLOSED bank raises that bank's bit of bank_open after the same edge. It also loads row_addr into that bank's slice of open_row, so bank 0 is bits [ROW_W-1:0].
- R3: A read or write to a bank is legal only if it arrives at least T_RCD rising edges after that bank's activate. An earlier one raises acc_err for one cycle, raises neither col_rd nor col_wr, and changes no state.
- R4: A legal column command pulses col_rd (WE high) or col_wr (WE low) for exactly one cycle after its edge. It also sets col_bank to the addressed bank. col_rd and col_wr are never high together.
- R5: A read or write to a bank that is not open raises acc_err for one cycle and has no other effect.
- R6: An activate to a bank that is already open, whether for the same row or a different one, raises acc_err for one cycle. The open row, the delay and the burst state stay unchanged.
- R7: A precharge closes the addressed bank after its edge, from any open state, including during the delay. A precharge to a closed bank is not an error.
- R8: The two banks are independent. Column commands are accepted on consecutive edges, to the same bank or alternating between the banks.
- R9: bank_burst for a bank goes high after a legal column command to it. A burst stop clears it in both banks. A precharge clears it in the bank it addresses.
- R10: While cs_n is high, the strobes are ignored.
- R11: After reset, both banks are closed, bank_burst is zero, and col_rd, col_wr and acc_err are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| bank_addr | input | BA_W (1) | Addressed bank |
| row_addr | input | ROW_W (11) | Row address for activate |
| bank_open | output | NUM_BANKS (2) | Per-bank open flag |
| bank_burst | output | NUM_BANKS (2) | Per-bank burst-in-progress flag |
| open_row | output | NUM_BANKS x ROW_W | Open row per bank |
| col_rd | output | 1 | One-cycle legal read pulse |
| col_wr | output | 1 | One-cycle legal write pulse |
| col_bank | output | BA_W (1) | Bank of the last legal column command |
| acc_err | output | 1 | One-cycle illegal-access pulse |

## Verification
Every result of this block appears one rising edge after the command that causes it. This covers the open and burst flags, the open row, the read or write pulse and the error pulse. The bench drives each command on a falling edge and compares all outputs on the next falling edge, against a model that advances one command per edge. The model decides whether the delay has elapsed by subtracting edge indices, so it needs no mirror of the design's counter. A sweep of every gap from 1 to T_RCD+1 on both banks pins the delay boundary. A long mixed command stream then covers alternating banks, back-to-back columns and illegal accesses.

// File: rtl/brt_pkg.sv
package brt_pkg;
    typedef enum logic [2:0] {
        CMD_NOP,
        CMD_ACT,
        CMD_PRE,
        CMD_RD,
        CMD_WR,
        CMD_BST,
        CMD_OTHER
    } cmd_e;

    typedef enum logic [1:0] {
        BK_CLOSED,
        BK_RCD_WAIT,
        BK_ACTIVE,
        BK_BURST
    } bank_st_e;
endpackage

// File: rtl/brt_cmd_decode.sv
module brt_cmd_decode
    import brt_pkg::*;
(
    input  logic cs_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    output cmd_e cmd
);
    always_comb begin
        if (cs_n) begin
            cmd = CMD_NOP;
        end else begin
            unique case ({ras_n, cas_n, we_n})
                3'b011:  cmd = CMD_ACT;
                3'b010:  cmd = CMD_PRE;
                3'b101:  cmd = CMD_RD;
                3'b100:  cmd = CMD_WR;
                3'b110:  cmd = CMD_BST;
                3'b111:  cmd = CMD_NOP;
                default: cmd = CMD_OTHER;
            endcase
        end
    end
endmodule

// File: rtl/brt_bank_fsm.sv
module brt_bank_fsm
    import brt_pkg::*;
#(
    parameter int ROW_W = 11,
    parameter int T_RCD = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  cmd_e             cmd,
    input  logic             sel,
    input  logic [ROW_W-1:0] row_in,
    output logic             open_o,
    output logic             burst_o,
    output logic [ROW_W-1:0] row_o,
    output logic             col_ok_o,
    output logic             err_o
);
    localparam int CW = (T_RCD > 1) ? $clog2(T_RCD) : 1;
    localparam logic [CW-1:0] CNT_LOAD = CW'(T_RCD - 1);

    bank_st_e         st_q, st_d;
    logic [CW-1:0]    cnt_q;
    logic [ROW_W-1:0] row_q;
    logic             is_col, ready, act_ok;

    assign is_col = sel && (cmd == CMD_RD || cmd == CMD_WR);
    assign ready  = (st_q == BK_ACTIVE) || (st_q == BK_BURST) ||
                    (st_q == BK_RCD_WAIT && cnt_q == '0);
    assign act_ok = sel && cmd == CMD_ACT && st_q == BK_CLOSED;

    always_comb begin
        st_d     = st_q;
        col_ok_o = 1'b0;
        err_o    = 1'b0;
        unique case (st_q)
            BK_CLOSED: begin
                if (act_ok) st_d = BK_RCD_WAIT;
                else if (is_col) err_o = 1'b1;
            end
            BK_RCD_WAIT, BK_ACTIVE, BK_BURST: begin
                if (sel && cmd == CMD_PRE) begin
                    st_d = BK_CLOSED;
                end else if (sel && cmd == CMD_ACT) begin
                    err_o = 1'b1;
                end else if (is_col) begin
                    if (ready) begin
                        col_ok_o = 1'b1;
                        st_d     = BK_BURST;
                    end else begin
                        err_o = 1'b1;
                    end
                end else if (st_q == BK_BURST && cmd == CMD_BST) begin
                    st_d = BK_ACTIVE;
                end else if (st_q == BK_RCD_WAIT && cnt_q == '0) begin
                    st_d = BK_ACTIVE;
                end
            end
            default: st_d = BK_CLOSED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= BK_CLOSED;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            row_q <= '0;
        end else begin
            if (act_ok) begin
                cnt_q <= CNT_LOAD;
                row_q <= row_in;
            end else if (st_q == BK_RCD_WAIT && cnt_q != '0) begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    assign open_o  = (st_q != BK_CLOSED);
    assign burst_o = (st_q == BK_BURST);
    assign row_o   = row_q;

    AST_ACT_LOADS_ROW: assert property (@(posedge clk) disable iff (!rst_n)
        act_ok |=> (st_q == BK_RCD_WAIT && row_q == $past(row_in))); // R2
    AST_PRE_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && cmd == CMD_PRE) |=> (st_q == BK_CLOSED)); // R7
    AST_ROW_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != BK_CLOSED) |=> (st_q == BK_CLOSED || $stable(row_q))); // R6
    AST_BST_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_BST && !(is_col)) |=> (st_q != BK_BURST)); // R9
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_LOAD); // R3
endmodule

// File: rtl/bank_row_tracker.sv
module bank_row_tracker
    import brt_pkg::*;
#(
    parameter int NUM_BANKS = 2,
    parameter int ROW_W     = 11,
    parameter int T_RCD     = 3,
    localparam int BA_W     = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                cs_n,
    input  logic                                ras_n,
    input  logic                                cas_n,
    input  logic                                we_n,
    input  logic [BA_W-1:0]                     bank_addr,
    input  logic [ROW_W-1:0]                    row_addr,
    output logic [NUM_BANKS-1:0]                bank_open,
    output logic [NUM_BANKS-1:0]                bank_burst,
    output logic [NUM_BANKS-1:0][ROW_W-1:0]     open_row,
    output logic                                col_rd,
    output logic                                col_wr,
    output logic [BA_W-1:0]                     col_bank,
    output logic                                acc_err
);
    cmd_e                 cmd;
    logic [NUM_BANKS-1:0] col_ok, bank_err;

    brt_cmd_decode u_dec (
        .cs_n  (cs_n),
        .ras_n (ras_n),
        .cas_n (cas_n),
        .we_n  (we_n),
        .cmd   (cmd)
    );

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        brt_bank_fsm #(.ROW_W(ROW_W), .T_RCD(T_RCD)) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .cmd      (cmd),
            .sel      (bank_addr == BA_W'(g)),
            .row_in   (row_addr),
            .open_o   (bank_open[g]),
            .burst_o  (bank_burst[g]),
            .row_o    (open_row[g]),
            .col_ok_o (col_ok[g]),
            .err_o    (bank_err[g])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            col_rd   <= 1'b0;
            col_wr   <= 1'b0;
            col_bank <= '0;
            acc_err  <= 1'b0;
        end else begin
            col_rd  <= (|col_ok) && cmd == CMD_RD;
            col_wr  <= (|col_ok) && cmd == CMD_WR;
            acc_err <= |bank_err;
            if (|col_ok) col_bank <= bank_addr;
        end
    end

    AST_RW_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(col_rd && col_wr)); // R4
    AST_ERR_NO_COL: assert property (@(posedge clk) disable iff (!rst_n)
        acc_err |-> !(col_rd || col_wr)); // R3
    AST_DESEL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> !(col_rd || col_wr || acc_err)); // R10
    AST_ONE_BANK_ACT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(col_ok | bank_err)); // R8
endmodule

// File: tb/sim_bank_row_tracker.sv
module sim_bank_row_tracker;
    localparam int NB   = 2;
    localparam int RW   = 11;
    localparam int TRCD = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [0:0] bank_addr = '0;
    logic [RW-1:0] row_addr = '0;
    logic [NB-1:0] bank_open, bank_burst;
    logic [NB-1:0][RW-1:0] open_row;
    logic col_rd, col_wr, acc_err;
    logic [0:0] col_bank;

    int n_run = 0, n_fail = 0, cyc = 0;
    bit done = 0;
    bit m_open[NB], m_burst[NB];
    int m_row[NB], m_act[NB];

    always #10 clk = ~clk;

    bank_row_tracker #(.NUM_BANKS(NB), .ROW_W(RW), .T_RCD(TRCD)) u0 (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
        .we_n(we_n), .bank_addr(bank_addr), .row_addr(row_addr),
        .bank_open(bank_open), .bank_burst(bank_burst), .open_row(open_row),
        .col_rd(col_rd), .col_wr(col_wr), .col_bank(col_bank), .acc_err(acc_err)
    );

    task automatic chk(int act, int exp, string tag, string what);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // c: 0 NOP, 1 ACT, 2 PRE, 3 RD, 4 WR, 5 BST, 6 other code, 7 deselected
    task automatic step(int c, int b, int r);
        int e_rd = 0, e_wr = 0, e_err = 0;
        string tag = "R1";
        cs_n = (c == 7);
        bank_addr = 1'(b);
        row_addr = RW'(r);
        case (c)
            1: {ras_n, cas_n, we_n} = 3'b011;
            2: {ras_n, cas_n, we_n} = 3'b010;
            3: {ras_n, cas_n, we_n} = 3'b101;
            4: {ras_n, cas_n, we_n} = 3'b100;
            5: {ras_n, cas_n, we_n} = 3'b110;
            6: {ras_n, cas_n, we_n} = 3'b001;
            7: {ras_n, cas_n, we_n} = 3'b100;
            default: {ras_n, cas_n, we_n} = 3'b111;
        endcase
        cyc++;
        case (c)
            1: if (m_open[b]) begin e_err = 1; tag = "R6"; end
               else begin
                   m_open[b] = 1; m_row[b] = r; m_act[b] = cyc; m_burst[b] = 0; tag = "R2";
               end
            2: begin m_open[b] = 0; m_burst[b] = 0; tag = "R7"; end
            3, 4: if (!m_open[b]) begin e_err = 1; tag = "R5"; end
                  else if (cyc - m_act[b] < TRCD) begin e_err = 1; tag = "R3"; end
                  else begin
                      if (c == 3) e_rd = 1; else e_wr = 1;
                      m_burst[b] = 1; tag = "R4";
                  end
            5: begin for (int k = 0; k < NB; k++) m_burst[k] = 0; tag = "R9"; end
            7: tag = "R10";
            default: tag = "R1";
        endcase
        @(negedge clk);
        chk(col_rd, e_rd, tag, "col_rd");
        chk(col_wr, e_wr, tag, "col_wr");
        chk(acc_err, e_err, tag, "acc_err");
        if (e_rd || e_wr) chk(col_bank, b, "R8", "col_bank");
        for (int k = 0; k < NB; k++) begin
            chk(bank_open[k], m_open[k], tag, "bank_open");
            chk(bank_burst[k], m_burst[k], "R9", "bank_burst");
            if (m_open[k]) chk(open_row[k], m_row[k], tag, "open_row");
        end
    endtask

    initial begin
        for (int k = 0; k < NB; k++) begin
            m_open[k] = 0; m_burst[k] = 0; m_row[k] = 0; m_act[k] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk(bank_open, 0, "R11", "bank_open");
        chk(bank_burst, 0, "R11", "bank_burst");
        chk(col_rd | col_wr | acc_err, 0, "R11", "pulses");
        // R3 delay boundary sweep per bank, read and write
        for (int b = 0; b < NB; b++)
            for (int gap = 1; gap <= TRCD + 1; gap++) begin
                step(2, b, 0);
                step(1, b, 7 + gap);
                for (int i = 1; i < gap; i++) step(0, b, 0);
                step((gap % 2) ? 3 : 4, b, 0);
            end
        // R6 re-activate open bank, R5 closed bank access
        step(1, 0, 99); step(1, 1, 5);
        step(2, 0, 0); step(3, 0, 0); step(4, 0, 0);
        // R8 alternating and back-to-back columns
        step(1, 0, 12);
        for (int i = 0; i < TRCD; i++) step(0, 0, 0);
        for (int i = 0; i < 12; i++) step(3 + (i % 2), i % 2, 0);
        for (int i = 0; i < 4; i++) step(4, 1, 0);
        step(5, 0, 0); step(7, 0, 0); step(6, 1, 0);
        step(2, 1, 0); step(2, 1, 0);
        // mixed stream
        for (int i = 0; i < 3000; i++) begin
            int p = $urandom_range(0, 9);
            int c = (p < 2) ? 1 : (p == 2) ? 2 : (p < 5) ? 3 : (p < 7) ? 4 :
                    (p == 7) ? 5 : (p == 8) ? 0 : 6 + $urandom_range(0, 1);
            step(c, $urandom_range(0, 1), $urandom_range(0, 3) * 5);
        end
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_run++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule